// File: doc/BRIEF.md
# Bit Manipulation Execution Unit

This unit carries out a family of bit-level operations on 32-bit or 64-bit operands for a processor datapath. The issuing logic presents an operation code, a width select and two operands with a one-cycle start pulse. The unit answers with a result word plus a zero flag and a carry flag, and marks completion with a one-cycle done pulse.

The operations are:
- field extraction, where one operand packs both the start position and the length;
- isolating, masking up to, or clearing the lowest set bit;
- clearing high bits from a given index upward;
- scatter (deposit) and gather (extract) of bits under a mask;
- leading-zero, trailing-zero and population counts;
- AND with an inverted second operand.

Most operations complete one cycle after the start pulse. Deposit and extract walk the set bits of the mask, one per cycle. While they run, the unit raises busy and ignores further start pulses.

Top module: `bitop_unit`

## Requirements
- R1: Operation code 0 (field extract) returns the operand A bits beginning at the position given by B[7:0], for the number of bits given by B[15:8], aligned to bit 0. Positions at or beyond the operand width read as zero, and a length beyond the width is clipped. Carry is 0.
- R2: Code 1 returns a word that holds only the lowest set bit of A. It returns zero when A is zero. Carry is 1 when A is non-zero.
- R3: Code 2 returns ones in every position from bit 0 up to and including the lowest set bit of A. It returns all ones across the operand width when A is zero, and carry is 1 exactly in that case.
- R4: Code 3 returns A with its lowest set bit cleared. Carry is 1 when A is zero.
- R5: Code 4 returns A with every bit at and above the index B[7:0] cleared. Carry is 1 when the index is at or beyond the operand width, and A is then returned unchanged.
- R6: Code 5 (deposit) places the low-order bits of A, in order, into the positions of the set bits of mask B, from lowest to highest. All other result bits are zero.
- R7: Code 6 (extract) packs the bits of A found at the set positions of mask B into consecutive result bits starting at bit 0. The lowest mask position goes to bit 0.
- R8: Code 7 counts zeros from the top bit of the operand width downward to the first one. Code 8 counts zeros from bit 0 upward. For a zero operand both return the operand width and set carry. Otherwise carry is 0.
- R9: Code 9 returns the number of ones in A. Code 10 returns A AND NOT B. Carry is 0 for both.
- R10: With wide_i low, the operation works on bits 31:0 only. Bits 63:32 of both operands are ignored, and result bits 63:32 are zero.
- R11: Codes other than 5 and 6 raise done exactly one cycle after the accepted start. Busy stays low for them.
- R12: Codes 5 and 6 raise busy from the cycle after start. Done arrives popcount(mask within the width) + 2 cycles after start, with busy falling at the same time. Start pulses while busy are ignored and leave the pending result unchanged.
- R13: The zero flag is 1 exactly when the result is zero. Codes 11 to 15 return zero with carry 0. After reset, busy and done are low and the result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse, taken when busy is low |
| op_i | input | 4 | Operation code |
| wide_i | input | 1 | 1 selects 64-bit operands, 0 selects 32-bit |
| opa_i | input | 64 | Operand A (data / source) |
| opb_i | input | 64 | Operand B (control, index or mask) |
| busy_o | output | 1 | Deposit or extract in progress |
| done_o | output | 1 | One-cycle completion pulse; result and flags valid |
| res_o | output | 64 | Result word, held until the next completion |
| zf_o | output | 1 | Zero flag of the result |
| cf_o | output | 1 | Carry flag as defined per operation |

## Verification
The timing properties assume that no start pulse arrives in the two cycles after reset release, while the internal reset synchronizer is still clearing. The stimulus therefore waits several cycles after reset before issuing work. They also take the width select and the operation code as stable at the start edge. The bench drives both with the start pulse from the falling edge. The only start pulses that land while busy are deliberate ones: they carry a different code and operands, to show that they are ignored.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  typedef enum logic [3:0] {
    OP_FEXT = 4'd0,
    OP_ISOL = 4'd1,
    OP_MSKL = 4'd2,
    OP_RSTL = 4'd3,
    OP_ZHI  = 4'd4,
    OP_PDEP = 4'd5,
    OP_PEXT = 4'd6,
    OP_LZC  = 4'd7,
    OP_TZC  = 4'd8,
    OP_POPC = 4'd9,
    OP_ANDN = 4'd10
  } bmu_op_e;
endpackage

// File: rtl/bmu_count.sv
module bmu_count #(
  parameter int W = 64
) (
  input  logic [W-1:0]         val_i,
  input  logic                 wide_i,
  output logic [$clog2(W):0]   lz_o,
  output logic [$clog2(W):0]   tz_o,
  output logic [$clog2(W):0]   pc_o
);
  localparam int CW = $clog2(W) + 1;
  localparam int H  = W / 2;
  localparam logic [CW-1:0] FULL = CW'(W);
  localparam logic [CW-1:0] HALF = CW'(H);

  logic [W-1:0]  view;
  logic [CW-1:0] lz_raw, tz_raw, pc_raw;
  logic          lz_hit, tz_hit;

  always_comb begin
    // narrow mode: move the low half to the top so the scan starts at bit 31
    view   = wide_i ? val_i : {val_i[H-1:0], {H{1'b0}}};
    lz_raw = FULL;
    lz_hit = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!lz_hit && view[i]) begin
        lz_raw = CW'(W - 1 - i);
        lz_hit = 1'b1;
      end
    end
    tz_raw = FULL;
    tz_hit = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (!tz_hit && val_i[i]) begin
        tz_raw = CW'(i);
        tz_hit = 1'b1;
      end
    end
    pc_raw = '0;
    for (int i = 0; i < W; i++) begin
      pc_raw = pc_raw + CW'(val_i[i]);
    end
  end

  assign lz_o = (!wide_i && lz_raw > HALF) ? HALF : lz_raw;
  assign tz_o = (!wide_i && tz_raw > HALF) ? HALF : tz_raw;
  assign pc_o = pc_raw;
endmodule

// File: rtl/bmu_simple.sv
module bmu_simple
  import bmu_pkg::*;
#(
  parameter int W = 64
) (
  input  bmu_op_e              op_i,
  input  logic                 wide_i,
  input  logic [W-1:0]         a_i,
  input  logic [W-1:0]         b_i,
  input  logic [$clog2(W):0]   lz_i,
  input  logic [$clog2(W):0]   tz_i,
  input  logic [$clog2(W):0]   pc_i,
  output logic [W-1:0]         res_o,
  output logic                 cf_o
);
  localparam int SW = $clog2(W);
  localparam logic [7:0] LIM_W = 8'(W);
  localparam logic [7:0] LIM_N = 8'(W / 2);
  localparam logic [W-1:0] ONE = W'(1);

  logic [7:0]   pos, len, lim;
  logic [W-1:0] shifted, fmask;

  always_comb begin
    pos     = b_i[7:0];
    len     = b_i[15:8];
    lim     = wide_i ? LIM_W : LIM_N;
    shifted = (pos >= LIM_W) ? '0 : (a_i >> pos[SW-1:0]);
    fmask   = (len >= LIM_W) ? '1 : ((ONE << len[SW-1:0]) - ONE);
    res_o   = '0;
    cf_o    = 1'b0;
    case (op_i)
      OP_FEXT: res_o = shifted & fmask;
      OP_ISOL: begin
        res_o = a_i & (~a_i + ONE);
        cf_o  = |a_i;
      end
      OP_MSKL: begin
        res_o = a_i ^ (a_i - ONE);
        cf_o  = ~|a_i;
      end
      OP_RSTL: begin
        res_o = a_i & (a_i - ONE);
        cf_o  = ~|a_i;
      end
      OP_ZHI: begin
        cf_o  = (pos >= lim);
        res_o = cf_o ? a_i : (a_i & ((ONE << pos[SW-1:0]) - ONE));
      end
      OP_LZC: begin
        res_o = W'(lz_i);
        cf_o  = ~|a_i;
      end
      OP_TZC: begin
        res_o = W'(tz_i);
        cf_o  = ~|a_i;
      end
      OP_POPC: res_o = W'(pc_i);
      OP_ANDN: res_o = a_i & ~b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/bmu_scatter.sv
module bmu_scatter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         dep_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] mask_i,
  output logic         busy_o,
  output logic         fin_o,
  output logic [W-1:0] res_o
);
  localparam int SW = $clog2(W);
  localparam int CW = SW + 1;
  localparam logic [W-1:0] ONE = W'(1);

  logic          busy_q, busy_n;
  logic          dep_q, dep_n;
  logic [W-1:0]  mask_q, mask_n;
  logic [W-1:0]  src_q, src_n;
  logic [W-1:0]  acc_q, acc_n;
  logic [CW-1:0] k_q, k_n;
  logic [W-1:0]  low;
  logic          en;

  assign low = mask_q & (~mask_q + ONE);
  assign en  = load_i | busy_q;

  always_comb begin
    busy_n = busy_q;
    dep_n  = dep_q;
    mask_n = mask_q;
    src_n  = src_q;
    acc_n  = acc_q;
    k_n    = k_q;
    if (load_i) begin
      busy_n = 1'b1;
      dep_n  = dep_i;
      mask_n = mask_i;
      src_n  = src_i;
      acc_n  = '0;
      k_n    = '0;
    end else if (busy_q) begin
      if (mask_q == '0) begin
        busy_n = 1'b0;
      end else begin
        if (dep_q) begin
          if (src_q[k_q[SW-1:0]]) acc_n = acc_q | low;
        end else if (|(src_q & low)) begin
          acc_n = acc_q | (ONE << k_q[SW-1:0]);
        end
        mask_n = mask_q & (mask_q - ONE);
        k_n    = k_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dep_q  <= 1'b0;
      mask_q <= '0;
      src_q  <= '0;
      acc_q  <= '0;
      k_q    <= '0;
    end else if (en) begin
      busy_q <= busy_n;
      dep_q  <= dep_n;
      mask_q <= mask_n;
      src_q  <= src_n;
      acc_q  <= acc_n;
      k_q    <= k_n;
    end
  end

  assign busy_o = busy_q;
  assign fin_o  = busy_q && (mask_q == '0);
  assign res_o  = acc_q;
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bmu_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [3:0]   op_i,
  input  logic         wide_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] res_o,
  output logic         zf_o,
  output logic         cf_o
);
  localparam int H  = W / 2;
  localparam int CW = $clog2(W) + 1;

  logic [1:0]    rs_q;
  logic          core_rst_n;
  bmu_op_e       op;
  logic [W-1:0]  wmask, a_m, b_m;
  logic          is_iter, accept, simple_go;
  logic [CW-1:0] lz, tz, pc;
  logic [W-1:0]  simple_res, scat_res;
  logic          simple_cf, scat_busy, scat_fin;
  logic          done_q, done_n;
  logic [W-1:0]  res_q, res_n;
  logic          zf_q, zf_n, cf_q, cf_n;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign core_rst_n = rs_q[1];

  assign op        = bmu_op_e'(op_i);
  assign wmask     = wide_i ? {W{1'b1}} : {{H{1'b0}}, {H{1'b1}}};
  assign a_m       = opa_i & wmask;
  assign b_m       = opb_i & wmask;
  assign is_iter   = (op == OP_PDEP) || (op == OP_PEXT);
  assign accept    = start_i && !scat_busy;
  assign simple_go = accept && !is_iter;

  bmu_count #(.W(W)) u_count (
    .val_i  (a_m),
    .wide_i (wide_i),
    .lz_o   (lz),
    .tz_o   (tz),
    .pc_o   (pc)
  );

  bmu_simple #(.W(W)) u_simple (
    .op_i   (op),
    .wide_i (wide_i),
    .a_i    (a_m),
    .b_i    (b_m),
    .lz_i   (lz),
    .tz_i   (tz),
    .pc_i   (pc),
    .res_o  (simple_res),
    .cf_o   (simple_cf)
  );

  bmu_scatter #(.W(W)) u_scatter (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .load_i (accept && is_iter),
    .dep_i  (op == OP_PDEP),
    .src_i  (a_m),
    .mask_i (b_m),
    .busy_o (scat_busy),
    .fin_o  (scat_fin),
    .res_o  (scat_res)
  );

  always_comb begin
    done_n = 1'b0;
    res_n  = res_q;
    cf_n   = cf_q;
    if (simple_go) begin
      done_n = 1'b1;
      res_n  = simple_res & wmask;
      cf_n   = simple_cf;
    end else if (scat_fin) begin
      done_n = 1'b1;
      res_n  = scat_res;
      cf_n   = 1'b0;
    end
    zf_n = ~|res_n;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_n;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      res_q <= '0;
      zf_q  <= 1'b1;
      cf_q  <= 1'b0;
    end else if (done_n) begin
      res_q <= res_n;
      zf_q  <= zf_n;
      cf_q  <= cf_n;
    end
  end

  assign busy_o = scat_busy;
  assign done_o = done_q;
  assign res_o  = res_q;
  assign zf_o   = zf_q;
  assign cf_o   = cf_q;
endmodule

// File: rtl/bmu_checker.sv
module bmu_checker #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic [3:0]   op_i,
  input logic         wide_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] res_o,
  input logic         zf_o
);
  logic       wide_q;
  logic [3:0] op_q;
  logic       iter_in;

  assign iter_in = (op_i == 4'd5) || (op_i == 4'd6);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q <= 1'b1;
      op_q   <= 4'd0;
    end else if (start_i && !busy_o) begin
      wide_q <= wide_i;
      op_q   <= op_i;
    end
  end

  p_simple_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && !iter_in |=> done_o && !busy_o);

  p_iter_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && iter_in |=> busy_o && !done_o);

  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_busy_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  p_narrow_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !wide_q |-> res_o[W-1:W/2] == '0);

  p_zero_flag_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (zf_o == (res_o == '0)));

  p_count_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && (op_q == 4'd7 || op_q == 4'd8) |-> res_o <= (wide_q ? W : W / 2));
endmodule

bind bitop_unit bmu_checker #(.W(W)) u_bmu_checker (
  .clk     (clk),
  .rst_n   (core_rst_n),
  .start_i (start_i),
  .op_i    (op_i),
  .wide_i  (wide_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .res_o   (res_o),
  .zf_o    (zf_o)
);

// File: tb/tb_bitop_unit.sv
module tb_bitop_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [3:0]  op_i;
  logic        wide_i;
  logic [63:0] opa_i, opb_i;
  logic        busy_o, done_o, zf_o, cf_o;
  logic [63:0] res_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bitop_unit #(.W(64)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .wide_i(wide_i),
    .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
    .res_o(res_o), .zf_o(zf_o), .cf_o(cf_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference: result, carry, latency in cycles
  function automatic void model(input logic [3:0] op, input bit wide,
                                input logic [63:0] ain, input logic [63:0] bin,
                                output logic [63:0] r, output bit cf, output int lat);
    logic [63:0] a, b;
    int w, s, l, x, k, n;
    w = wide ? 64 : 32;
    a = ain; b = bin;
    if (!wide) begin a[63:32] = '0; b[63:32] = '0; end
    r = '0; cf = 0; lat = 1;
    case (op)
      4'd0: begin
        s = int'(b[7:0]); l = int'(b[15:8]);
        for (int i = 0; i < l && i < 64; i++) if (s + i < w) r[i] = a[s+i];
      end
      4'd1: begin
        for (int i = 0; i < w; i++) if (a[i]) begin r[i] = 1'b1; break; end
        cf = (a != 0);
      end
      4'd2: begin
        for (int i = 0; i < w; i++) begin r[i] = 1'b1; if (a[i]) break; end
        cf = (a == 0);
      end
      4'd3: begin
        r = a;
        for (int i = 0; i < w; i++) if (a[i]) begin r[i] = 1'b0; break; end
        cf = (a == 0);
      end
      4'd4: begin
        x = int'(b[7:0]);
        for (int i = 0; i < w; i++) if (i < x) r[i] = a[i];
        cf = (x >= w);
      end
      4'd5: begin
        k = 0;
        for (int i = 0; i < w; i++) if (b[i]) begin r[i] = a[k]; k++; end
        lat = k + 2;
      end
      4'd6: begin
        k = 0;
        for (int i = 0; i < w; i++) if (b[i]) begin r[k] = a[i]; k++; end
        lat = k + 2;
      end
      4'd7: begin
        n = 0;
        for (int i = w - 1; i >= 0; i--) begin if (a[i]) break; n++; end
        r = 64'(n); cf = (a == 0);
      end
      4'd8: begin
        n = 0;
        for (int i = 0; i < w; i++) begin if (a[i]) break; n++; end
        r = 64'(n); cf = (a == 0);
      end
      4'd9:  r = 64'($countones(a));
      4'd10: r = a & ~b;
      default: r = '0;
    endcase
  endfunction

  // issue one operation; compare busy/done every cycle until completion
  task automatic run(input logic [3:0] op, input bit wide, input logic [63:0] a,
                     input logic [63:0] b, input bit poke, input string tag);
    logic [63:0] er;
    bit ecf;
    int lat;
    model(op, wide, a, b, er, ecf, lat);
    @(negedge clk);
    start_i = 1'b1; op_i = op; wide_i = wide; opa_i = a; opb_i = b;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 1; k <= lat; k++) begin
      if (k > 1) @(negedge clk);
      start_i = 1'b0;
      if (k < lat) begin
        chk(busy_o === 1'b1 && done_o === 1'b0, {tag, " busy phase R12"},
            {62'd0, busy_o, done_o}, 64'd2);
        if (poke && k == 2) begin
          start_i = 1'b1; op_i = 4'd9; opa_i = '1; opb_i = '1; wide_i = 1'b1;
        end
      end else begin
        chk(done_o === 1'b1 && busy_o === 1'b0, {tag, " done timing R11 R12"},
            {62'd0, busy_o, done_o}, 64'd1);
        chk(res_o === er, {tag, " result"}, res_o, er);
        chk(zf_o === (er == 0), {tag, " zero flag R13"}, 64'(zf_o), 64'(er == 0));
        chk(cf_o === ecf, {tag, " carry"}, 64'(cf_o), 64'(ecf));
      end
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; op_i = '0; wide_i = 1'b1; opa_i = '0; opb_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy_o === 1'b0 && done_o === 1'b0 && res_o === '0, "reset state R13",
        res_o, 64'd0);

    // R1 field extract
    run(4'd0, 1, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_0804, 0, "R1 mid field");
    run(4'd0, 1, 64'hF123_4567_89AB_CDEF, 64'h0000_0000_0000_0A3C, 0, "R1 clip top");
    run(4'd0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_20C8, 0, "R1 start beyond");
    run(4'd0, 1, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_FF00, 0, "R1 long length");
    run(4'd0, 0, 64'hFFFF_FFFF_8765_4321, 64'h0000_0000_0000_101C, 0, "R1 R10 narrow");
    // R2 isolate
    run(4'd1, 1, 64'hA000_0000_0000_0080, 64'h0, 0, "R2 isolate");
    run(4'd1, 1, 64'h0, 64'h0, 0, "R2 zero");
    run(4'd1, 0, 64'h0000_0001_0000_0000, 64'h0, 0, "R2 R10 upper ignored");
    // R3 mask through lowest
    run(4'd2, 1, 64'h0000_0000_0000_0050, 64'h0, 0, "R3 mask");
    run(4'd2, 1, 64'h0, 64'h0, 0, "R3 zero wide");
    run(4'd2, 0, 64'hFFFF_0000_0000_0000, 64'h0, 0, "R3 R10 zero narrow");
    // R4 reset lowest
    run(4'd3, 1, 64'h8000_0000_0000_0C00, 64'h0, 0, "R4 clear lowest");
    run(4'd3, 1, 64'h0, 64'h0, 0, "R4 zero");
    // R5 zero high
    run(4'd4, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd12, 0, "R5 index 12");
    run(4'd4, 1, 64'hDEAD_BEEF_0BAD_F00D, 64'd64, 0, "R5 index at width");
    run(4'd4, 0, 64'hDEAD_BEEF_0BAD_F00D, 64'd40, 0, "R5 R10 narrow beyond");
    run(4'd4, 1, 64'h1234_5678_9ABC_DEF0, 64'd0, 0, "R5 index 0");
    // R6 deposit
    run(4'd5, 1, 64'h0000_0000_0000_0005, 64'h8000_0000_0000_0F00, 0, "R6 deposit");
    run(4'd5, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 0, "R6 empty mask");
    run(4'd5, 0, 64'h0000_0000_DEAD_BEEF, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R6 R10 full narrow");
    // R7 extract
    run(4'd6, 1, 64'hF000_0000_0000_00A0, 64'hC000_0000_0000_00F0, 0, "R7 extract");
    run(4'd6, 1, 64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_0000_FFFF, 1, "R7 R12 start ignored");
    run(4'd5, 1, 64'h0000_0000_0000_00FF, 64'h0101_0101_0101_0101, 1, "R6 R12 start ignored");
    // R8 counts
    run(4'd7, 1, 64'h0000_1000_0000_0000, 64'h0, 0, "R8 lead wide");
    run(4'd7, 1, 64'h0, 64'h0, 0, "R8 lead zero wide");
    run(4'd7, 0, 64'hFFFF_FFFF_0000_0000, 64'h0, 0, "R8 R10 lead zero narrow");
    run(4'd7, 0, 64'h0000_0000_0000_8000, 64'h0, 0, "R8 lead narrow");
    run(4'd8, 1, 64'h8000_0000_0000_0000, 64'h0, 0, "R8 trail top");
    run(4'd8, 0, 64'h8000_0000_0000_0000, 64'h0, 0, "R8 R10 trail zero narrow");
    // R9 popcount and and-not
    run(4'd9, 1, 64'hF0F0_0000_0000_0003, 64'h0, 0, "R9 popcount");
    run(4'd9, 0, 64'hFFFF_FFFF_0000_0007, 64'h0, 0, "R9 R10 popcount narrow");
    run(4'd10, 1, 64'hFF00_FF00_FF00_FF00, 64'hF0F0_F0F0_F0F0_F0F0, 0, "R9 and-not");
    run(4'd10, 1, 64'h1234, 64'hFFFF, 0, "R9 and-not zero");
    // R13 undefined code
    run(4'd13, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF, 0, "R13 undefined code");
    // back-to-back mix
    for (int i = 0; i < 6; i++) begin
      run(4'(i % 11), (i % 2) == 0, 64'h9E37_79B9_7F4A_7C15 * 64'(i + 3),
          64'h0000_0000_0000_1F07 ^ 64'(i * 17), 0, "R11 mixed sequence");
    end
    summary();
  end
endmodule